// File: doc/BRIEF.md
# Self-Timed Byte-Wide Nonvolatile Memory Controller

This block models the control logic of an 8K x 8 electrically erasable byte memory that is driven like a static RAM. A host drives three active-low strobes (chip select, output enable, write strobe), a 13-bit address and an 8-bit data bus. The bus is split into input, output and output-enable ports. A read returns the stored byte. A write is latched internally and then carried out without further help from the host. An internal timer first erases the target byte to all ones and then programs the latched value.

While a write is in progress the block reports busy in two ways. A ready output is pulled low. A read of any address returns the inverse of the latched bit 7 on the top data bit until programming is finished. A host may therefore either wait on the ready line or poll bit 7 until it matches the value it wrote. A separate 32-byte identification area sits beside the main array and is selected with a dedicated input. All strobes, the address, the data and the area select are resynchronised to the internal clock before they are used. The length of the write is a parameter in clock cycles.

Top module: `nvm_byte_mem`

## Requirements
- R1: After reset `rdy_o` is 1 and `dq_oe` is 0.
- R2: With `ce_n`=0, `oe_n`=0 and `we_n`=1 held steady, `dq_oe` goes to 1 and, when idle, `dq_o` carries the byte stored at `addr`. In any other strobe combination `dq_oe` is 0.
- R3: A write starts when `ce_n` and `we_n` are both low with `oe_n` high. Whichever of the two falls later triggers it. Address, data and area select are captured at that point, and later changes on those inputs during the write have no effect.
- R4: Strobe patterns with `oe_n` low never start a write: `rdy_o` stays 1 and the array is unchanged.
- R5: Each write holds `rdy_o` at 0 for exactly WR_CYCLES clock cycles (default 64).
- R6: During the first WR_CYCLES/2 busy cycles (the erase phase), a read of the target byte returns 1 on bits 6..0.
- R7: During the second phase the latched byte is programmed. After `rdy_o` returns to 1, a read of the target returns that byte.
- R8: While `rdy_o` is 0, bit 7 of any read returns the inverse of the latched data bit 7. Bits 6..0 show the array contents at the read address.
- R9: Write attempts made while `rdy_o` is 0 are ignored, and no byte other than the current target changes.
- R10: With `id_sel`=1, reads and writes use a separate 32-byte area addressed by `addr[4:0]`. The main array at the same address is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| id_sel | input | 1 | 1 selects the 32-byte identification area |
| addr | input | 13 | Byte address |
| dq_i | input | 8 | Data bus, host to memory |
| dq_o | output | 8 | Data bus, memory to host |
| dq_oe | output | 1 | 1 while the memory drives the data bus |
| rdy_o | output | 1 | 0 (driven low) while a write is in progress |

## Verification
The assertions check three things on every cycle:
- the idle state right after reset;
- that the data bus is driven only three cycles after a genuine read strobe combination;
- that every busy window lasts exactly the programmed number of cycles, and that the polled top bit never toggles inside one.

The remaining behaviour can only be shown through bench scenarios. This covers the all-ones erase value seen mid-write and the programmed value afterwards. It also covers latching that survives bus changes, trigger order of the two strobes, ignored writes with output enable low or during busy, and separation of the identification area from the main array.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2
  } wr_phase_t;
endpackage

// File: rtl/nvm_sync.sv
`timescale 1ns/1ps
// Multi-stage resynchroniser for a bundle of asynchronous inputs.
module nvm_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nvm_store.sv
`timescale 1ns/1ps
// Single write port, registered read port: block RAM friendly.
module nvm_store #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvm_capture.sv
`timescale 1ns/1ps
// Decodes synchronised strobes, detects write start, holds write latches.
module nvm_capture #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic          id_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  input  logic          busy,
  output logic          wr_start,
  output logic          rd_en,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_data,
  output logic          lat_id
);
  logic wr_low;
  logic wr_low_q;

  // write level: both strobes low, output enable high
  assign wr_low   = !ce_s && !we_s && oe_s;
  // later falling edge of the pair produces the rising edge of wr_low
  assign wr_start = wr_low && !wr_low_q && !busy;
  assign rd_en    = !ce_s && !oe_s && we_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_low_q <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
      lat_id   <= 1'b0;
    end else begin
      wr_low_q <= wr_low;
      if (wr_start) begin
        lat_addr <= addr_s;
        lat_data <= data_s;
        lat_id   <= id_s;
      end
    end
  end
endmodule

// File: rtl/nvm_wtimer.sv
`timescale 1ns/1ps
// Self-timed erase-then-program sequencer.
module nvm_wtimer
  import nvm_pkg::*;
#(
  parameter int WR_CYCLES = 64
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output wr_phase_t phase,
  output logic      busy,
  output logic      wr_en,
  output logic      wr_erase
);
  localparam int ERASE_CYC = WR_CYCLES / 2;
  localparam int PROG_CYC  = WR_CYCLES - ERASE_CYC;
  localparam int CW        = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_ERASE;
            cnt   <= CW'(ERASE_CYC - 1);
          end
        end
        PH_ERASE: begin
          if (cnt == '0) begin
            phase <= PH_PROG;
            cnt   <= CW'(PROG_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_PROG: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign wr_en    = busy;
  assign wr_erase = (phase == PH_ERASE);
endmodule

// File: rtl/nvm_byte_mem.sv
`timescale 1ns/1ps
module nvm_byte_mem
  import nvm_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int ID_AW       = 5,
  parameter int WR_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              rdy_o
);
  localparam int SW = 4 + ADDR_W + DATA_W;
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {(SW-3){1'b0}}};

  logic [SW-1:0]     raw_bus, syn_bus;
  logic              ce_s, oe_s, we_s, id_s;
  logic [ADDR_W-1:0] addr_s, lat_addr;
  logic [DATA_W-1:0] data_s, lat_data;
  logic              lat_id, wr_start, rd_en;
  wr_phase_t         phase;
  logic              busy, wr_en, wr_erase;
  logic [DATA_W-1:0] wdata, rd_main, rd_id, rd_byte;
  logic              main_we, id_we;
  logic              oe_q, poll_q, sel_id_q;

  assign raw_bus = {ce_n, oe_n, we_n, id_sel, addr, dq_i};

  nvm_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
  );

  assign {ce_s, oe_s, we_s, id_s, addr_s, data_s} = syn_bus;

  nvm_capture #(.AW(ADDR_W), .DW(DATA_W)) u_cap (
    .clk(clk), .rst(rst),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .id_s(id_s),
    .addr_s(addr_s), .data_s(data_s), .busy(busy),
    .wr_start(wr_start), .rd_en(rd_en),
    .lat_addr(lat_addr), .lat_data(lat_data), .lat_id(lat_id)
  );

  nvm_wtimer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(wr_start),
    .phase(phase), .busy(busy), .wr_en(wr_en), .wr_erase(wr_erase)
  );

  assign wdata   = wr_erase ? {DATA_W{1'b1}} : lat_data;
  assign main_we = wr_en && !lat_id;
  assign id_we   = wr_en && lat_id;

  nvm_store #(.AW(ADDR_W), .DW(DATA_W)) u_main (
    .clk(clk), .we(main_we), .waddr(lat_addr), .wdata(wdata),
    .raddr(addr_s), .rdata(rd_main)
  );

  nvm_store #(.AW(ID_AW), .DW(DATA_W)) u_ident (
    .clk(clk), .we(id_we), .waddr(lat_addr[ID_AW-1:0]), .wdata(wdata),
    .raddr(addr_s[ID_AW-1:0]), .rdata(rd_id)
  );

  // output-side flags registered alongside the array read register
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q     <= 1'b0;
      poll_q   <= 1'b0;
      sel_id_q <= 1'b0;
    end else begin
      oe_q     <= rd_en;
      poll_q   <= busy;
      sel_id_q <= id_s;
    end
  end

  assign rd_byte = sel_id_q ? rd_id : rd_main;
  assign dq_o    = poll_q ? {~lat_data[DATA_W-1], rd_byte[DATA_W-2:0]} : rd_byte;
  assign dq_oe   = oe_q;
  assign rdy_o   = ~busy;
endmodule

// File: rtl/nvm_chk.sv
`timescale 1ns/1ps
module nvm_chk #(
  parameter int WR_CYCLES = 64,
  parameter int DW        = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          rdy_o,
  input logic          dq_oe,
  input logic [DW-1:0] dq_o
);
  logic [1:0] age;
  int         busy_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      age      <= '0;
      busy_run <= 0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      if (!rdy_o) busy_run <= busy_run + 1;
      else        busy_run <= 0;
    end
  end

  // R1: idle outputs on the first cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdy_o && !dq_oe));

  // R2: bus is driven exactly when a read strobe was seen three cycles back
  a_r2_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (dq_oe == $past(!ce_n && !oe_n && we_n, 3)));

  // R5: busy window length
  a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_o) |-> (busy_run == WR_CYCLES));

  // R8: polled bit is steady inside a busy window
  a_r8_poll_steady: assert property (@(posedge clk) disable iff (rst)
    (!rdy_o && !$past(rdy_o) && !$past(rdy_o, 2) && dq_oe && $past(dq_oe))
      |-> $stable(dq_o[DW-1]));
endmodule

bind nvm_byte_mem nvm_chk #(.WR_CYCLES(WR_CYCLES), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .rdy_o(rdy_o), .dq_oe(dq_oe), .dq_o(dq_o)
);

// File: tb/tb_nvm_byte_mem.sv
`timescale 1ns/1ps
module tb_nvm_byte_mem;
  localparam int WR = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, id_sel = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe, rdy_o;

  int n_run  = 0;
  int n_fail = 0;
  int run_len = 0;
  int last_len = 0;
  bit done = 1'b0;

  logic [8:0] exp_q [$];
  string      tag_q [$];
  event       sample_ev;

  always #4 clk = ~clk;

  nvm_byte_mem dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .id_sel(id_sel), .addr(addr), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe(dq_oe), .rdy_o(rdy_o)
  );

  // busy-window length observed at the port
  always @(negedge clk) begin
    if (!rst) begin
      if (!rdy_o) run_len++;
      else begin
        if (run_len != 0) last_len = run_len;
        run_len = 0;
      end
    end
  end

  // monitor: pops expected {oe,data} items and compares at the sample point
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() != 0) begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if ({dq_oe, dq_o} !== e) begin
          n_fail++;
          $display("FAIL %s: actual oe=%0b data=%h expected oe=%0b data=%h",
                   t, dq_oe, dq_o, e[8], e[7:0]);
        end
      end
    end
  end

  task automatic expect_bus(input logic oe, input logic [7:0] d, input string t);
    exp_q.push_back({oe, d});
    tag_q.push_back(t);
    ->sample_ev;
    #1;
  endtask

  task automatic check(input bit ok, input string t, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, expv);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input bit ids, input logic [12:0] a, input logic [7:0] d,
                          input bit we_first);
    @(negedge clk);
    oe_n = 1'b1; id_sel = ids; addr = a; dq_i = d;
    if (we_first) we_n = 1'b0; else ce_n = 1'b0;
    cycles(2);
    if (we_first) ce_n = 1'b0; else we_n = 1'b0;
    cycles(4);
    addr = ~a; dq_i = ~d;   // bus reused after capture
    cycles(3);
    ce_n = 1'b1; we_n = 1'b1; id_sel = 1'b0;
  endtask

  task automatic read_on(input bit ids, input logic [12:0] a);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; id_sel = ids; addr = a;
    cycles(4);
  endtask

  task automatic read_off();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; id_sel = 1'b0;
    cycles(2);
  endtask

  task automatic wait_ready();
    while (rdy_o !== 1'b1) @(negedge clk);
    cycles(3);
  endtask

  initial begin
    cycles(4);
    rst = 1'b0;
    cycles(2);
    check(rdy_o === 1'b1, "R1 ready after reset", rdy_o, 1);
    check(dq_oe === 1'b0, "R1 bus released after reset", dq_oe, 0);

    // write 0x0123 <= A5, write strobe first; observe erase and program phases
    do_write(1'b0, 13'h0123, 8'hA5, 1'b1);
    read_on(1'b0, 13'h0123);
    expect_bus(1'b1, 8'h7F, "R6 R8 erase phase shows ones, bit7 inverted");
    cycles(30);
    expect_bus(1'b1, 8'h25, "R8 program phase poll");
    read_off();
    wait_ready();
    check(last_len == WR, "R5 busy length", last_len, WR);
    read_on(1'b0, 13'h0123);
    expect_bus(1'b1, 8'hA5, "R7 R3 programmed byte despite bus reuse");
    read_off();

    // write 0x1FFF <= 3C, chip select falls last
    do_write(1'b0, 13'h1FFF, 8'h3C, 1'b0);
    read_on(1'b0, 13'h1FFF);
    cycles(30);
    expect_bus(1'b1, 8'hBC, "R8 poll inverts zero bit7");
    read_off();
    wait_ready();
    read_on(1'b0, 13'h1FFF);
    expect_bus(1'b1, 8'h3C, "R3 later-falling chip select triggers write");
    read_off();

    // R2: no drive when chip select is high
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = 13'h0123;
    cycles(4);
    expect_bus(1'b0, dq_o, "R2 no drive without chip select");
    oe_n = 1'b1;

    // R4: strobes with output enable low are not a write
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 13'h0123; dq_i = 8'h00;
    cycles(6);
    check(rdy_o === 1'b1, "R4 no busy with output enable low", rdy_o, 1);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    cycles(2);
    read_on(1'b0, 13'h0123);
    expect_bus(1'b1, 8'hA5, "R4 array unchanged");
    read_off();

    // R9: writes during busy are ignored
    do_write(1'b0, 13'h0040, 8'h11, 1'b1);
    do_write(1'b0, 13'h0123, 8'h00, 1'b1);
    do_write(1'b0, 13'h0040, 8'h99, 1'b0);
    wait_ready();
    check(last_len == WR, "R5 R9 single busy window", last_len, WR);
    cycles(8);
    check(rdy_o === 1'b1, "R9 no deferred write", rdy_o, 1);
    read_on(1'b0, 13'h0123);
    expect_bus(1'b1, 8'hA5, "R9 other byte untouched");
    read_off();
    read_on(1'b0, 13'h0040);
    expect_bus(1'b1, 8'h11, "R9 target keeps first value");
    read_off();

    // R10: identification area is separate
    do_write(1'b0, 13'h0003, 8'hC3, 1'b1);
    wait_ready();
    do_write(1'b1, 13'h0003, 8'h5A, 1'b0);
    wait_ready();
    read_on(1'b1, 13'h0003);
    expect_bus(1'b1, 8'h5A, "R10 id area read");
    read_off();
    read_on(1'b0, 13'h0003);
    expect_bus(1'b1, 8'hC3, "R10 main array unaffected");
    read_off();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule